// File: doc/BRIEF.md
# Urgency-Ordered Shared Register Updater

This block holds two W-bit two's-complement registers, `x` and `y`, and four update
activities that want to modify them. Each activity has a request input. On every clock
edge the block decides which activities take effect, applying a fixed urgency ranking
and the overlap between the registers each activity writes. An activity that takes
effect applies all of its register changes in that cycle. An activity that does not
take effect applies none of them. The block also reports which activities took effect,
so the surrounding logic can observe the schedule.

An activity is held back only by a more urgent activity that is itself taking effect
and that writes at least one register in common with it. The `FULL` parameter selects
one of two configurations. The full one has four activities. The reduced one has three
activities, and in it the most urgent activity writes only `y`. In the reduced
configuration the lowest activity can therefore take effect alongside the most urgent
one, even though it is blocked by the middle activity.

Top module: `shared_reg_updater`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `x_o` equals `X_INIT`, `y_o` equals `Y_INIT` and `fire_o` is 0.
- R2: Activity 2 is the most urgent, so `cond_i[2]` always makes `fire_o[2]` set one cycle later. In the full configuration it adds 1 to `x` and subtracts 1 from `y`. In the reduced configuration it only subtracts 1 from `y`.
- R3: In the full configuration, activity 3 takes effect when `cond_i[3]` is high and `cond_i[2]` is low. It adds 2 to `x` and subtracts 2 from `y`.
- R4: Activity 1 adds 1 to `y` and subtracts 1 from `x`. In the full configuration it takes effect only when neither activity 2 nor activity 3 takes effect. In the reduced configuration it takes effect when `cond_i[2]` is low.
- R5: Activity 0 adds 1 to `x`. In the full configuration it takes effect only when `cond_i[0]` is the only request among the four.
- R6: In the reduced configuration, activity 0 takes effect exactly when `cond_i[0]` is high and either `cond_i[1]` is low or `cond_i[2]` is high. It can therefore take effect in the same cycle as activity 2.
- R7: In the reduced configuration, `cond_i[3]` has no effect: `fire_o[3]` stays 0 and `x_o` and `y_o` are unchanged by it.
- R8: At most one activity writes each register per cycle. A register that no active activity writes keeps its value. `fire_o` bit k (bit k = activity k) reports the activities whose updates appear in the same cycle as the new `x_o`/`y_o`.
- R9: All arithmetic wraps modulo 2^W.
- R10: For all 16 combinations of `cond_i`, in both configurations, the results match a model that visits the activities in the urgency order 2, 3, 1, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cond_i | input | 4 | Request of each activity, bit k = activity k |
| x_o | output | W | Register x |
| y_o | output | W | Register y |
| fire_o | output | 4 | Activities applied at the last edge, bit k = activity k |

## Verification
Every result is registered once. A request pattern present at a rising edge shows up in
`x_o`, `y_o` and `fire_o` right after that edge, with no further latency. The driver
changes `cond_i` on the falling edge and queues the expected values of both
configurations. The monitor pops one queued item 1 ns after each rising edge and
compares it, so every comparison lands on the cycle in which the result first appears.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int NPROC = 4;
    localparam int REG_X = 0;
    localparam int REG_Y = 1;

    // Activity visited at a given urgency rank (rank 0 = most urgent)
    function automatic int urgency(input int rank);
        case (rank)
            0:       return 2;
            1:       return 3;
            2:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit present(input bit full, input int p);
        return (p < 3) || full;
    endfunction

    // bit REG_X = writes x, bit REG_Y = writes y
    function automatic logic [1:0] wmask(input bit full, input int p);
        case (p)
            0:       return 2'b01;
            1:       return 2'b11;
            2:       return full ? 2'b11 : 2'b10;
            default: return full ? 2'b11 : 2'b00;
        endcase
    endfunction

    function automatic int dx(input bit full, input int p);
        case (p)
            0:       return 1;
            1:       return -1;
            2:       return full ? 1 : 0;
            default: return 2;
        endcase
    endfunction

    function automatic int dy(input int p);
        case (p)
            0:       return 0;
            1:       return 1;
            2:       return -1;
            default: return -2;
        endcase
    endfunction

    function automatic logic [NPROC-1:0] writers(input bit full, input int r);
        logic [NPROC-1:0] m;
        m = '0;
        for (int p = 0; p < NPROC; p++) begin
            m[p] = wmask(full, p)[r] & present(full, p);
        end
        return m;
    endfunction

endpackage

// File: rtl/sru_sched.sv
module sru_sched
    import sru_pkg::*;
#(
    parameter bit FULL = 1'b1
) (
    input  logic [NPROC-1:0] cond_i,
    output logic [NPROC-1:0] fire_o
);
    logic [1:0] claimed;

    // Visit activities by urgency; one fires if no firing, more urgent one shares a register
    always_comb begin
        claimed = '0;
        fire_o  = '0;
        for (int r = 0; r < NPROC; r++) begin
            if (cond_i[urgency(r)] && present(FULL, urgency(r)) &&
                ((wmask(FULL, urgency(r)) & claimed) == 2'b00)) begin
                fire_o[urgency(r)] = 1'b1;
                claimed = claimed | wmask(FULL, urgency(r));
            end
        end
    end
endmodule

// File: rtl/sru_update.sv
module sru_update
    import sru_pkg::*;
#(
    parameter bit FULL = 1'b1,
    parameter int W    = 8
) (
    input  logic [NPROC-1:0] fire_i,
    input  logic [W-1:0]     x_i,
    input  logic [W-1:0]     y_i,
    output logic [W-1:0]     x_o,
    output logic [W-1:0]     y_o
);
    logic [W-1:0] step_x;
    logic [W-1:0] step_y;

    // The scheduler guarantees a single writer per register, so OR-combining is a mux
    always_comb begin
        step_x = '0;
        step_y = '0;
        for (int p = 0; p < NPROC; p++) begin
            if (fire_i[p] && wmask(FULL, p)[REG_X]) step_x = step_x | W'(dx(FULL, p));
            if (fire_i[p] && wmask(FULL, p)[REG_Y]) step_y = step_y | W'(dy(p));
        end
        x_o = x_i + step_x;
        y_o = y_i + step_y;
    end
endmodule

// File: rtl/shared_reg_updater.sv
module shared_reg_updater
    import sru_pkg::*;
#(
    parameter bit          FULL   = 1'b1,
    parameter int          W      = 8,
    parameter logic [W-1:0] X_INIT = '0,
    parameter logic [W-1:0] Y_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPROC-1:0] cond_i,
    output logic [W-1:0]     x_o,
    output logic [W-1:0]     y_o,
    output logic [NPROC-1:0] fire_o
);
    localparam logic [NPROC-1:0] XW = writers(FULL, REG_X);
    localparam logic [NPROC-1:0] YW = writers(FULL, REG_Y);

    typedef struct packed {
        logic [W-1:0]     x;
        logic [W-1:0]     y;
        logic [NPROC-1:0] fire;
    } state_t;

    state_t            st_d, st_q;
    logic [NPROC-1:0]  fire_c;
    logic [W-1:0]      x_c, y_c;

    sru_sched #(.FULL(FULL)) u_sched (
        .cond_i (cond_i),
        .fire_o (fire_c)
    );

    sru_update #(.FULL(FULL), .W(W)) u_update (
        .fire_i (fire_c),
        .x_i    (st_q.x),
        .y_i    (st_q.y),
        .x_o    (x_c),
        .y_o    (y_c)
    );

    always_comb begin
        st_d.x    = x_c;
        st_d.y    = y_c;
        st_d.fire = fire_c;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.x    <= X_INIT;
            st_q.y    <= Y_INIT;
            st_q.fire <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign x_o    = st_q.x;
    assign y_o    = st_q.y;
    assign fire_o = st_q.fire;

    // Most urgent request is always granted
    p_urgent_wins_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cond_i[2])) |-> fire_o[2]);

    // A register nobody wrote keeps its value
    p_hold_x_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ((fire_o & XW) == '0)) |-> (x_o == $past(x_o)));
    p_hold_y_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ((fire_o & YW) == '0)) |-> (y_o == $past(y_o)));

    // Single writer per register
    p_one_writer_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fire_o & XW) && $onehot0(fire_o & YW));

    // Lone increment of x
    p_inc_x_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (fire_o == 4'b0001)) |-> (x_o == $past(x_o) + W'(1)));

    // Reduced configuration has no activity 3
    p_no_act3_r7: assert property (@(posedge clk) disable iff (rst)
        !FULL |-> !fire_o[3]);
endmodule

// File: tb/shared_reg_updater_tb.sv
module shared_reg_updater_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] cond = '0;
    logic [W-1:0] xf, yf, xr, yr;
    logic [3:0] ff, fr;

    always #2.5 clk = ~clk;

    shared_reg_updater #(.FULL(1'b1), .W(W)) u_dut (
        .clk(clk), .rst(rst), .cond_i(cond), .x_o(xf), .y_o(yf), .fire_o(ff));
    shared_reg_updater #(.FULL(1'b0), .W(W)) u_dut_red (
        .clk(clk), .rst(rst), .cond_i(cond), .x_o(xr), .y_o(yr), .fire_o(fr));

    typedef struct {
        logic [W-1:0] fx, fy, rx, ry;
        logic [3:0]   ffire, rfire;
        string        tag;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic [W-1:0] mfx, mfy, mrx, mry;

    task automatic check(input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] c, input string tag);
        item_t it;
        logic [3:0] f;
        @(negedge clk);
        cond = c;
        // full model, urgency 2,3,1,0
        f = '0;
        if (c[2])      begin f[2] = 1; mfx = mfx + 1; mfy = mfy - 1; end
        else if (c[3]) begin f[3] = 1; mfx = mfx + 2; mfy = mfy - 2; end
        else if (c[1]) begin f[1] = 1; mfx = mfx - 1; mfy = mfy + 1; end
        else if (c[0]) begin f[0] = 1; mfx = mfx + 1; end
        it.ffire = f; it.fx = mfx; it.fy = mfy;
        // reduced model: activity 2 touches y only, no activity 3
        f = '0;
        if (c[2])      begin f[2] = 1; mry = mry - 1; end
        else if (c[1]) begin f[1] = 1; mry = mry + 1; mrx = mrx - 1; end
        if (c[0] && !f[1]) begin f[0] = 1; mrx = mrx + 1; end
        it.rfire = f; it.rx = mrx; it.ry = mry;
        it.tag = tag;
        q.push_back(it);
    endtask

    // Monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                check(it.tag, "full.fire", W'(ff), W'(it.ffire));
                check(it.tag, "full.x", xf, it.fx);
                check(it.tag, "full.y", yf, it.fy);
                check(it.tag, "red.fire", W'(fr), W'(it.rfire));
                check(it.tag, "red.x", xr, it.rx);
                check(it.tag, "red.y", yr, it.ry);
            end
        end
    end

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        mfx = '0; mfy = '0; mrx = '0; mry = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "full.x", xf, '0);
        check("R1", "full.y", yf, '0);
        check("R1", "full.fire", W'(ff), '0);
        check("R1", "red.fire", W'(fr), '0);
        rst = 1'b0;
        step(4'b0000, "R8");          // no request: both registers hold
        step(4'b1000, "R9");          // y wraps 0 -> FE in full, R7 in reduced
        step(4'b1000, "R7");
        step(4'b1111, "R2");
        step(4'b0100, "R2");
        step(4'b1011, "R3");
        step(4'b1010, "R3");
        step(4'b0011, "R4");
        step(4'b0010, "R4");
        step(4'b0001, "R5");
        step(4'b0111, "R6");
        step(4'b0101, "R6");
        step(4'b0000, "R8");
        for (int i = 0; i < 16; i++) step(4'(i), "R10");
        for (int i = 15; i >= 0; i--) step(4'(i), "R10");
        for (int i = 0; i < 150; i++) step(4'b1000, "R9");   // long wrap run
        for (int i = 0; i < 300; i++) step(4'((i * 7 + 3) % 16), "R10");
        step(4'b0000, "R8");
        @(negedge clk);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule